// File: doc/BRIEF.md
# Multiple-Winner Three-Step Motion Search Controller

This controller runs a coarse-to-fine block-matching search for one macro-block. It does not touch pixels. It hands motion-vector offsets, one at a time, to an external engine that computes the sum of absolute differences (SAD), and it takes back one SAD for each offset. A single-winner three-step search follows only the best point from one step to the next. This controller instead keeps the three lowest-cost locations found so far and searches around each of them at the next, halved step size. After the last step, which uses a step size of one, it reports the best offset and its SAD.

A search begins with a one-cycle `start` pulse while the controller is idle. The first step tries the window centre and its eight neighbours at distance 4. Each of the two later steps tries the eight neighbours of each of the three held centres, at distance 2 and then at distance 1. Every search therefore issues exactly 57 candidates.

Only one candidate is outstanding at a time. The controller keeps `cand_valid` high until `cand_ready` accepts the candidate, then waits for `sad_valid`. It ranks every returned SAD in a three-entry sorted tracker. The tracker is cleared at the start of each search and keeps its entries from step to step.

Top module: `msearch_ctrl`

## Requirements
- R1: During and after synchronous active-low reset, `cand_valid` and `done` are 0 and `best_dx`, `best_dy` and `best_sad` are 0.
- R2: The first step issues offset (0,0) first, then the eight points at distance 4 in row-major order: the row dy=-4 first, each row with dx rising, and the centre skipped.
- R3: Steps two and three use distances 2 and 1. They visit the three held centres in rank order, best first, and issue the eight neighbours of each centre in the same row-major order, never the centre itself. The centres are the three lowest SADs returned so far in the current search. A SAD equal to a held one ranks below it.
- R4: Offsets are 4-bit two's-complement values. Any coordinate beyond ±WIN (the parameter for the search range, in pixels) is clamped to the nearest window edge.
- R5: Each search issues exactly 57 candidates. After the 57th SAD no further candidate is offered.
- R6: Only one request is outstanding. `cand_valid` and the offsets hold steady until `cand_ready` is seen, and `cand_valid` stays low until the SAD for that request has returned.
- R7: `done` is a one-cycle pulse at the end of a search. `best_dx`, `best_dy` and `best_sad` then give the lowest SAD of the search, the earliest one on a tie, and they hold until the next search completes.
- R8: `start` has no effect while a search is running. `sad_valid` has no effect unless a SAD is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (acted on only when idle) |
| cand_valid | output | 1 | A candidate offset is offered |
| cand_ready | input | 1 | SAD engine accepts the offered candidate |
| cand_dx | output | 4 | Candidate horizontal offset, two's complement |
| cand_dy | output | 4 | Candidate vertical offset, two's complement |
| sad_valid | input | 1 | SAD for the accepted candidate is present |
| sad_value | input | 16 | SAD of the accepted candidate |
| done | output | 1 | One-cycle pulse: result is valid |
| best_dx | output | 4 | Winning horizontal offset |
| best_dy | output | 4 | Winning vertical offset |
| best_sad | output | 16 | SAD of the winning offset |

## Verification
A corrupted rank in the tracker shows up first as a wrong centre, and so as a wrong offset, on the very first candidate of the next step. A wrong step counter or index shows the same way within one candidate of the fault. The bench therefore compares all 57 offsets of every search, not only the final result. The sweep moves the cost minimum across every offset in the window, using separable linear costs with frequent ties and a scrambled multi-minimum cost. It uses a narrowed window so that clamping is exercised. Stray `start` and `sad_valid` pulses are injected mid-search; if the controller reacted to them, the candidate stream would diverge at once.

// File: rtl/msearch_pkg.sv
// Package: shared state encoding and neighbour-order helpers for the
// multiple-winner motion search. Neighbour codes 0..7 walk the 3x3 ring
// in row-major order with the centre removed. Unit codes: 2'b11 = -1,
// 2'b00 = 0, 2'b01 = +1.
package msearch_pkg;

    typedef enum logic [2:0] {
        MS_IDLE,
        MS_ISSUE,
        MS_WAIT,
        MS_ADV,
        MS_FIN
    } ms_state_t;

    // Horizontal unit direction of ring neighbour n
    function automatic logic [1:0] nb_unit_x(input logic [2:0] n);
        case (n)
            3'd0, 3'd3, 3'd5: nb_unit_x = 2'b11;
            3'd1, 3'd6:       nb_unit_x = 2'b00;
            default:          nb_unit_x = 2'b01;
        endcase
    endfunction

    // Vertical unit direction of ring neighbour n
    function automatic logic [1:0] nb_unit_y(input logic [2:0] n);
        case (n)
            3'd0, 3'd1, 3'd2: nb_unit_y = 2'b11;
            3'd3, 3'd4:       nb_unit_y = 2'b00;
            default:          nb_unit_y = 2'b01;
        endcase
    endfunction

endpackage

// File: rtl/ms_offset.sv
// Module: ms_offset
// Forms one candidate offset: centre + unit * delta on each axis, clamped
// to +/-WIN. Purely combinational.
// Assumes: the centre is already inside the window, delta is at most
// 2**(OFFW-1), and the unit codes follow msearch_pkg.
module ms_offset #(
    parameter int OFFW = 4,
    parameter int WIN  = 7
) (
    input  logic [OFFW-1:0] cen_x,
    input  logic [OFFW-1:0] cen_y,
    input  logic [OFFW-1:0] delta,
    input  logic [1:0]      ux,
    input  logic [1:0]      uy,
    output logic [OFFW-1:0] off_x,
    output logic [OFFW-1:0] off_y
);
    localparam int EW = OFFW + 2;
    localparam logic signed [EW-1:0] LIM_HI = EW'(WIN);
    localparam logic signed [EW-1:0] LIM_LO = -EW'(WIN);

    generate
        for (genvar a = 0; a < 2; a++) begin : g_axis
            logic [OFFW-1:0]        cen_s;
            logic [1:0]             unit_s;
            logic signed [EW-1:0]   base;
            logic signed [EW-1:0]   stp;
            logic signed [EW-1:0]   raw;
            logic [OFFW-1:0]        res;

            assign cen_s  = (a == 0) ? cen_x : cen_y;
            assign unit_s = (a == 0) ? ux : uy;

            // Step from the centre along this axis, then clamp to the window
            always_comb begin
                base = EW'($signed(cen_s));
                stp  = EW'($signed({1'b0, delta}));
                case (unit_s)
                    2'b01:   raw = base + stp;
                    2'b11:   raw = base - stp;
                    default: raw = base;
                endcase
                if (raw > LIM_HI)
                    res = LIM_HI[OFFW-1:0];
                else if (raw < LIM_LO)
                    res = LIM_LO[OFFW-1:0];
                else
                    res = raw[OFFW-1:0];
            end
        end
    endgenerate

    assign off_x = g_axis[0].res;
    assign off_y = g_axis[1].res;

endmodule

// File: rtl/ms_top3.sv
// Module: ms_top3
// Sorted K-entry tracker of the lowest SADs with their offsets. Entry 0
// holds the lowest. An insert is placed above the first entry that it
// strictly beats or that is empty; the lower entries shift down and the
// last one is dropped. On equal SADs the earlier insert stays higher.
// Assumes: clear and ins are never high together.
module ms_top3 #(
    parameter int K    = 3,
    parameter int SADW = 16,
    parameter int OFFW = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      ins,
    input  logic [SADW-1:0]           ins_sad,
    input  logic [OFFW-1:0]           ins_x,
    input  logic [OFFW-1:0]           ins_y,
    output logic [K-1:0]              ent_vld,
    output logic [K-1:0][SADW-1:0]    ent_sad,
    output logic [K-1:0][OFFW-1:0]    ent_x,
    output logic [K-1:0][OFFW-1:0]    ent_y
);
    logic [K-1:0] beats;

    generate
        for (genvar i = 0; i < K; i++) begin : g_ent
            logic            vld_q;
            logic [SADW-1:0] sad_q;
            logic [OFFW-1:0] x_q;
            logic [OFFW-1:0] y_q;
            logic            above;

            assign beats[i] = !vld_q || (ins_sad < sad_q);

            if (i == 0) begin : g_head
                assign above = 1'b0;
            end else begin : g_tail
                assign above = beats[i-1];
            end

            // Entry update: take the new value, take the entry above, or hold
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    vld_q <= 1'b0;
                    sad_q <= '0;
                    x_q   <= '0;
                    y_q   <= '0;
                end else if (ins && beats[i]) begin
                    if (!above) begin
                        vld_q <= 1'b1;
                        sad_q <= ins_sad;
                        x_q   <= ins_x;
                        y_q   <= ins_y;
                    end else begin
                        vld_q <= ent_vld[(i == 0) ? 0 : i-1];
                        sad_q <= ent_sad[(i == 0) ? 0 : i-1];
                        x_q   <= ent_x[(i == 0) ? 0 : i-1];
                        y_q   <= ent_y[(i == 0) ? 0 : i-1];
                    end
                end
            end

            assign ent_vld[i] = vld_q;
            assign ent_sad[i] = sad_q;
            assign ent_x[i]   = x_q;
            assign ent_y[i]   = y_q;

            if (i > 0) begin : g_chk
                // R3: ranking stays sorted and filled from the top
                a_r3_sorted: assert property (@(posedge clk) disable iff (!rst_n)
                    ent_vld[i] |-> (ent_vld[i-1] && (ent_sad[i-1] <= ent_sad[i])));
            end
        end
    endgenerate

endmodule

// File: rtl/msearch_ctrl.sv
// Module: msearch_ctrl
// Sequencer for the multiple-winner three-step search. It issues the
// centre plus eight ring points at STEP0, then the eight ring points of
// each of K held centres at every halved step down to 1, with one request
// outstanding at a time. It ranks the returned SADs in ms_top3 and pulses
// done with the best entry.
// Assumes: the SAD engine returns exactly one sad_valid per accepted
// candidate, at least one cycle after acceptance.
module msearch_ctrl
    import msearch_pkg::*;
#(
    parameter int OFFW      = 4,
    parameter int SADW      = 16,
    parameter int WIN       = 7,
    parameter int K         = 3,
    parameter int STEP_LOG2 = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            cand_valid,
    input  logic            cand_ready,
    output logic [OFFW-1:0] cand_dx,
    output logic [OFFW-1:0] cand_dy,
    input  logic            sad_valid,
    input  logic [SADW-1:0] sad_value,
    output logic            done,
    output logic [OFFW-1:0] best_dx,
    output logic [OFFW-1:0] best_dy,
    output logic [SADW-1:0] best_sad
);
    localparam int NSTEP = STEP_LOG2 + 1;
    localparam int STEP0 = 1 << STEP_LOG2;
    localparam int SW    = $clog2(NSTEP + 1);
    localparam int CW    = $clog2(K + 1);
    localparam int TOTAL = 9 + 8 * K * (NSTEP - 1);
    localparam int NW    = $clog2(TOTAL + 1);

    ms_state_t              state;
    logic [SW-1:0]          step;
    logic [CW-1:0]          cidx;
    logic [3:0]             jidx;
    logic [K-1:0][OFFW-1:0] cen_x_q;
    logic [K-1:0][OFFW-1:0] cen_y_q;
    logic [NW-1:0]          issued_q;

    logic                   first_step;
    logic                   is_centre;
    logic                   last_in_step;
    logic                   last_step;
    logic [2:0]             nb;
    logic [1:0]             ux;
    logic [1:0]             uy;
    logic [OFFW-1:0]        cur_cx;
    logic [OFFW-1:0]        cur_cy;
    logic [OFFW-1:0]        delta;
    logic                   trk_clear;
    logic                   trk_ins;
    logic                   sad_take;

    logic [K-1:0]           ent_vld;
    logic [K-1:0][SADW-1:0] ent_sad;
    logic [K-1:0][OFFW-1:0] ent_x;
    logic [K-1:0][OFFW-1:0] ent_y;

    // Decode the current position in the search pattern
    always_comb begin
        first_step   = (step == '0);
        is_centre    = first_step && (jidx == 4'd0);
        nb           = first_step ? 3'(jidx - 4'd1) : jidx[2:0];
        ux           = is_centre ? 2'b00 : nb_unit_x(nb);
        uy           = is_centre ? 2'b00 : nb_unit_y(nb);
        cur_cx       = first_step ? '0 : cen_x_q[cidx];
        cur_cy       = first_step ? '0 : cen_y_q[cidx];
        delta        = OFFW'(STEP0 >> step);
        last_in_step = first_step ? (jidx == 4'd8)
                                  : ((jidx == 4'd7) && (cidx == CW'(K - 1)));
        last_step    = (step == SW'(NSTEP - 1));
    end

    assign cand_valid = (state == MS_ISSUE);
    assign sad_take   = (state == MS_WAIT) && sad_valid;
    assign trk_clear  = (state == MS_IDLE) && start;
    assign trk_ins    = sad_take;

    ms_offset #(
        .OFFW (OFFW),
        .WIN  (WIN)
    ) u_offset (
        .cen_x (cur_cx),
        .cen_y (cur_cy),
        .delta (delta),
        .ux    (ux),
        .uy    (uy),
        .off_x (cand_dx),
        .off_y (cand_dy)
    );

    ms_top3 #(
        .K    (K),
        .SADW (SADW),
        .OFFW (OFFW)
    ) u_rank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (trk_clear),
        .ins     (trk_ins),
        .ins_sad (sad_value),
        .ins_x   (cand_dx),
        .ins_y   (cand_dy),
        .ent_vld (ent_vld),
        .ent_sad (ent_sad),
        .ent_x   (ent_x),
        .ent_y   (ent_y)
    );

    // Search sequencer: walk steps, centres and ring points
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= MS_IDLE;
            step  <= '0;
            cidx  <= '0;
            jidx  <= '0;
        end else begin
            case (state)
                MS_IDLE: begin
                    if (start) begin
                        state <= MS_ISSUE;
                        step  <= '0;
                        cidx  <= '0;
                        jidx  <= '0;
                    end
                end
                MS_ISSUE: begin
                    if (cand_ready) state <= MS_WAIT;
                end
                MS_WAIT: begin
                    if (sad_valid) begin
                        if (last_in_step && last_step) begin
                            state <= MS_FIN;
                        end else if (last_in_step) begin
                            state <= MS_ADV;
                            step  <= step + 1'b1;
                            cidx  <= '0;
                            jidx  <= '0;
                        end else begin
                            state <= MS_ISSUE;
                            if (!first_step && (jidx == 4'd7)) begin
                                jidx <= '0;
                                cidx <= cidx + 1'b1;
                            end else begin
                                jidx <= jidx + 4'd1;
                            end
                        end
                    end
                end
                MS_ADV:  state <= MS_ISSUE;
                MS_FIN:  state <= MS_IDLE;
                default: state <= MS_IDLE;
            endcase
        end
    end

    // Latch the ranked winners as centres for the next step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cen_x_q <= '0;
            cen_y_q <= '0;
        end else if (state == MS_ADV) begin
            cen_x_q <= ent_x;
            cen_y_q <= ent_y;
        end
    end

    // Publish the best entry and pulse done once per search
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            best_dx  <= '0;
            best_dy  <= '0;
            best_sad <= '0;
        end else begin
            done <= 1'b0;
            if (state == MS_FIN) begin
                done     <= 1'b1;
                best_dx  <= ent_x[0];
                best_dy  <= ent_y[0];
                best_sad <= ent_sad[0];
            end
        end
    end

    // Count accepted candidates of the running search (checked below)
    always_ff @(posedge clk) begin
        if (!rst_n || trk_clear)
            issued_q <= '0;
        else if (cand_valid && cand_ready)
            issued_q <= issued_q + 1'b1;
    end

    // R6: an offered candidate is held unchanged until accepted
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_valid && !cand_ready) |=> (cand_valid && $stable(cand_dx) && $stable(cand_dy)));

    // R4: every offered offset lies within the window
    a_r4_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (($signed(cand_dx) <= WIN) && ($signed(cand_dx) >= -WIN) &&
                        ($signed(cand_dy) <= WIN) && ($signed(cand_dy) >= -WIN)));

    // R7: done lasts exactly one cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: a completed search accepted exactly the full candidate count
    a_r5_total: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (issued_q == NW'(TOTAL)));

    // R3: centres are latched only from a fully ranked tracker
    a_r3_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == MS_ADV) |-> (&ent_vld));

    // R8: start during an offered candidate does not restart the search
    a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == MS_ISSUE) && start && !cand_ready) |=> (state == MS_ISSUE));

endmodule

// File: tb/msearch_ctrl_tb_top.sv
`timescale 1ns/1ps
module msearch_ctrl_tb_top;
    localparam int TB_WIN = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        cand_ready = 1'b0;
    logic        sad_valid = 1'b0;
    logic [15:0] sad_value = '0;
    logic        cand_valid;
    logic [3:0]  cand_dx;
    logic [3:0]  cand_dy;
    logic        done;
    logic [3:0]  best_dx;
    logic [3:0]  best_dy;
    logic [15:0] best_sad;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    // cost model settings
    int g_mode, g_tx, g_ty, g_a, g_b, g_seed;

    // bench ranking model
    int  ms[3], mx[3], my[3];
    bit  mv[3];
    int  cx[3], cy[3];

    always #2 clk = ~clk;

    msearch_ctrl #(.WIN(TB_WIN)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cand_valid (cand_valid),
        .cand_ready (cand_ready),
        .cand_dx    (cand_dx),
        .cand_dy    (cand_dy),
        .sad_valid  (sad_valid),
        .sad_value  (sad_value),
        .done       (done),
        .best_dx    (best_dx),
        .best_dy    (best_dy),
        .best_sad   (best_sad)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int clampw(input int v);
        if (v > TB_WIN) return TB_WIN;
        if (v < -TB_WIN) return -TB_WIN;
        return v;
    endfunction

    function automatic int sad_of(input int x, input int y);
        if (g_mode == 0)
            return g_a * iabs(x - g_tx) + g_b * iabs(y - g_ty);
        return ((x + 8) * (y + 11) * (g_seed + 3) + g_seed * 7) % 23;
    endfunction

    // row-major ring without the centre
    function automatic int ring_x(input int n);
        if (n == 0 || n == 3 || n == 5) return -1;
        if (n == 1 || n == 6) return 0;
        return 1;
    endfunction

    function automatic int ring_y(input int n);
        if (n < 3) return -1;
        if (n < 5) return 0;
        return 1;
    endfunction

    task automatic model_insert(input int s, input int x, input int y);
        int p;
        p = 3;
        for (int i = 2; i >= 0; i--)
            if (!mv[i] || s < ms[i]) p = i;
        if (p < 3) begin
            for (int i = 2; i > p; i--) begin
                ms[i] = ms[i-1]; mx[i] = mx[i-1]; my[i] = my[i-1]; mv[i] = mv[i-1];
            end
            ms[p] = s; mx[p] = x; my[p] = y; mv[p] = 1'b1;
        end
    endtask

    task automatic run_search(input bit stray_sad, input bit busy_start);
        int s, c, j, kk, r, d, ex, ey, rx, ry, ax, ay, sv;
        bit ok, got;
        for (int i = 0; i < 3; i++) begin
            mv[i] = 0; ms[i] = 0; mx[i] = 0; my[i] = 0;
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 57; k++) begin
            if (k < 9) begin
                s = 0; c = 0; j = k;
            end else begin
                kk = k - 9; s = 1 + kk / 24; r = kk % 24; c = r / 8; j = r % 8;
            end
            if (k == 9 || k == 33)
                for (int i = 0; i < 3; i++) begin cx[i] = mx[i]; cy[i] = my[i]; end
            if (s == 0) begin
                if (j == 0) begin rx = 0; ry = 0; end
                else begin rx = 4 * ring_x(j - 1); ry = 4 * ring_y(j - 1); end
            end else begin
                d = 4 >> s;
                rx = cx[c] + d * ring_x(j);
                ry = cy[c] + d * ring_y(j);
            end
            ex = clampw(rx); ey = clampw(ry);
            got = 0;
            for (int t = 0; t < 20; t++) begin
                if (cand_valid) begin got = 1; break; end
                @(negedge clk);
            end
            chk(got, "R6", "candidate offered", int'(got), 1);
            if (!got) return;
            ax = int'($signed(cand_dx)); ay = int'($signed(cand_dy));
            if (rx != ex || ry != ey) begin
                chk(ax == ex, "R4", "clamped dx", ax, ex);
                chk(ay == ey, "R4", "clamped dy", ay, ey);
            end else if (s == 0) begin
                chk(ax == ex, "R2", "first-step dx", ax, ex);
                chk(ay == ey, "R2", "first-step dy", ay, ey);
            end else begin
                chk(ax == ex, "R3", "refine dx", ax, ex);
                chk(ay == ey, "R3", "refine dy", ay, ey);
            end
            if (stray_sad && k == 5) begin
                sad_valid = 1'b1; sad_value = 16'd0;
                @(negedge clk);
                sad_valid = 1'b0;
            end
            if (k % 3 == 0) begin
                @(negedge clk);
                ok = cand_valid && (int'($signed(cand_dx)) == ax) && (int'($signed(cand_dy)) == ay);
                chk(ok, "R6", "held before ready", int'(ok), 1);
            end
            cand_ready = 1'b1;
            @(negedge clk);
            cand_ready = 1'b0;
            chk(!cand_valid, "R6", "no offer while awaiting SAD", int'(cand_valid), 0);
            if (busy_start && k == 20) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
            if (k % 2 == 1) @(negedge clk);
            sv = sad_of(ax, ay);
            sad_valid = 1'b1; sad_value = 16'(sv);
            @(negedge clk);
            sad_valid = 1'b0;
            model_insert(sv, ax, ay);
        end
        got = 0;
        for (int t = 0; t < 10; t++) begin
            if (done) begin got = 1; break; end
            chk(!cand_valid, "R5", "no candidate beyond 57", int'(cand_valid), 0);
            @(negedge clk);
        end
        chk(got, "R7", "done pulse", int'(got), 1);
        chk(int'($signed(best_dx)) == mx[0], "R7", "best dx", int'($signed(best_dx)), mx[0]);
        chk(int'($signed(best_dy)) == my[0], "R7", "best dy", int'($signed(best_dy)), my[0]);
        chk(int'(best_sad) == ms[0], "R7", "best sad", int'(best_sad), ms[0]);
        @(negedge clk);
        chk(!done, "R7", "done one cycle", int'(done), 0);
        chk(!cand_valid, "R5", "idle after search", int'(cand_valid), 0);
        chk(int'(best_sad) == ms[0], "R7", "result held", int'(best_sad), ms[0]);
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !finished) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!cand_valid, "R1", "cand_valid in reset", int'(cand_valid), 0);
        chk(!done, "R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cand_valid && !done, "R1", "idle after reset", int'(cand_valid), 0);
        chk(best_sad == 16'd0 && best_dx == 4'd0 && best_dy == 4'd0,
            "R1", "result cleared", int'(best_sad), 0);
        // R8: sad_valid while idle leaves nothing behind
        sad_valid = 1'b1; sad_value = 16'd3;
        @(negedge clk);
        sad_valid = 1'b0;
        chk(!cand_valid && !done, "R8", "idle sad_valid ignored", int'(done), 0);

        g_mode = 0;
        for (int tx = -7; tx <= 7; tx++) begin
            for (int ty = -7; ty <= 7; ty++) begin
                g_tx = tx; g_ty = ty;
                g_a = 1 + ((tx + 7) % 3);
                g_b = 1 + ((ty + 7) % 2);
                run_search(((tx + ty) & 3) == 0, ((tx - ty) & 3) == 1);
            end
        end
        g_mode = 1;
        for (int sd = 0; sd < 20; sd++) begin
            g_seed = sd;
            run_search(sd % 2 == 0, sd % 3 == 0);
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule